// File: doc/BRIEF.md
# Program-Counter Sample Profiling Register

This block holds the most recent instruction address that a running core has sampled, together with the execution context of that sample. The core presents each new sample with a one-cycle strobe. The block keeps that sample in a live register. An external debugger then reads the block over a 32-bit register bus.

A read of the low-word offset returns address bits [31:0] of the live sample. In the same cycle it copies the upper half of the sample and the two context words (context ID and virtual context) into held registers. Later reads of the high-word, context-ID and virtual-context offsets therefore all describe the same sample as that low-word read, even if the core has moved on. The upper half is composed in one of two layouts, chosen by a format input at the moment of the low-word read.

The register bus is a valid/ready request channel paired with a valid/ready response channel. At most one response is outstanding. A request is accepted only when the response slot is empty or is being drained in that cycle, so `req_ready = !rsp_valid || rsp_ready`. While `rsp_ready` is low, a pending response keeps its data unchanged.

Top module: `pcs_profiler`

## Requirements
- R1: After reset the live sample is invalid, no branch is recorded, the held high, context-ID and virtual-context words read as zero, and `rsp_valid` is 0.
- R2: A low-word read (offset 0x0A0) of a valid sample returns address bits [31:0]. The held words then describe that same sample, and a later sample does not change them until the next low-word read.
- R3: A sample counts as valid only after `smp_valid` has strobed since reset and `branch_retired` has been seen high since reset. A low-word read of an invalid sample returns 0xFFFFFFFF and sets the held high, context-ID and virtual-context words to 0xFFFFFFFF.
- R4: While `sw_lock` is 1, a low-word read still returns its data, but the held high, context-ID and virtual-context words keep their previous values.
- R5: With `alt_fmt` = 0 at the low-word read, the held high word is address bits [63:32] when the sample's `smp_hv` is 1, and zero when it is 0.
- R6: With `alt_fmt` = 1 at the low-word read, the held high word has the following layout:
  - bit 31 is the Non-secure flag (1 = Non-secure);
  - bits [30:29] are the exception level (0 to 3);
  - bits [28:24] are zero;
  - bits [23:0] are address bits [55:32].
- R7: Reads of the high word (0x0AC), context ID (0x0A4) and virtual context (0x0A8) return the held words and change no state.
- R8: Writes to any offset change no state and complete with read data 0. Reads of unmapped offsets return 0.
- R9: `req_ready` equals `!rsp_valid || rsp_ready`. A response with `rsp_ready` low keeps `rsp_valid` high and `rsp_rdata` unchanged. An accepted request produces its response on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | One-cycle strobe that delivers a new sample |
| smp_addr | input | 64 | Sampled instruction address |
| smp_hv | input | 1 | Sample's upper-address-valid flag (used by the default layout) |
| smp_ns | input | 1 | Sample's Non-secure flag |
| smp_el | input | 2 | Sample's exception level |
| smp_ctx | input | 32 | Sample's context ID |
| smp_vctx | input | 32 | Sample's virtual-context word |
| branch_retired | input | 1 | A branch has retired in this cycle |
| alt_fmt | input | 1 | Selects the alternate high-word layout |
| sw_lock | input | 1 | Suppresses the snapshot side effect |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with `req_valid` |
| req_write | input | 1 | Request is a write (discarded) |
| req_addr | input | 12 | Byte offset of the request |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumed |
| rsp_rdata | output | 32 | Response read data |

## Verification
The low-word read is exercised with distinct address patterns under both high-word layouts and with both values of the upper-address-valid flag. This separates composition errors from snapshot errors.

Invalid-sample cases are tried separately with no strobe and with no retired branch, which shows that each condition alone gates validity. The same cases are repeated under the lock, so a missing suppression shows up in the held words.

A second sample that arrives after a low-word read tells a true snapshot apart from a pass-through of the live sample. Stalling the response channel checks that held data is stable and that the next request waits for the response slot to drain.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  localparam int unsigned PCS_ADDR_W = 12;
  localparam int unsigned PCS_WORD_W = 32;
  localparam int unsigned PCS_PC_W   = 64;

  localparam logic [PCS_ADDR_W-1:0] OFS_LO   = 12'h0A0;
  localparam logic [PCS_ADDR_W-1:0] OFS_CTX  = 12'h0A4;
  localparam logic [PCS_ADDR_W-1:0] OFS_VCTX = 12'h0A8;
  localparam logic [PCS_ADDR_W-1:0] OFS_HI   = 12'h0AC;

  typedef struct packed {
    logic [PCS_PC_W-1:0]   addr;
    logic                  hv;
    logic                  ns;
    logic [1:0]            el;
    logic [PCS_WORD_W-1:0] ctx;
    logic [PCS_WORD_W-1:0] vctx;
  } pcs_sample_t;
endpackage

// File: rtl/pcs_live.sv
module pcs_live
  import pcs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        smp_valid,
  input  pcs_sample_t smp_in,
  input  logic        branch_retired,
  output pcs_sample_t live,
  output logic        live_ok
);
  logic have_smp;
  logic have_br;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live     <= '0;
      have_smp <= 1'b0;
      have_br  <= 1'b0;
    end else begin
      if (smp_valid) begin
        live     <= smp_in;
        have_smp <= 1'b1;
      end
      if (branch_retired) have_br <= 1'b1;
    end
  end

  assign live_ok = have_smp && have_br;

  AST_OK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    live_ok |=> live_ok); // R3
endmodule

// File: rtl/pcs_fmt.sv
module pcs_fmt
  import pcs_pkg::*;
(
  input  pcs_sample_t           smp,
  input  logic                  alt_fmt,
  output logic [PCS_WORD_W-1:0] hi_word
);
  localparam int unsigned ALT_ADDR_W = 24;
  localparam int unsigned RSV_W      = PCS_WORD_W - ALT_ADDR_W - 3;

  always_comb begin
    if (alt_fmt) begin
      hi_word = {smp.ns, smp.el, {RSV_W{1'b0}},
                 smp.addr[PCS_WORD_W +: ALT_ADDR_W]};
    end else if (smp.hv) begin
      hi_word = smp.addr[PCS_PC_W-1:PCS_WORD_W];
    end else begin
      hi_word = '0;
    end
  end
endmodule

// File: rtl/pcs_regif.sv
module pcs_regif
  import pcs_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  pcs_sample_t           live,
  input  logic                  live_ok,
  input  logic [PCS_WORD_W-1:0] hi_fmt,
  input  logic                  sw_lock,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [PCS_ADDR_W-1:0] req_addr,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [PCS_WORD_W-1:0] rsp_rdata
);
  logic [PCS_WORD_W-1:0] held_hi, held_ctx, held_vctx;
  logic [PCS_WORD_W-1:0] rd_mux;
  logic fire, rd_lo;

  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;
  assign rd_lo     = !req_write && (req_addr == OFS_LO);

  always_comb begin
    rd_mux = '0;
    if (!req_write) begin
      unique case (req_addr)
        OFS_LO:   rd_mux = live_ok ? live.addr[PCS_WORD_W-1:0] : '1;
        OFS_HI:   rd_mux = held_hi;
        OFS_CTX:  rd_mux = held_ctx;
        OFS_VCTX: rd_mux = held_vctx;
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_hi   <= '0;
      held_ctx  <= '0;
      held_vctx <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      if (fire) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= rd_mux;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
      if (fire && rd_lo && !sw_lock) begin
        if (live_ok) begin
          held_hi   <= hi_fmt;
          held_ctx  <= live.ctx;
          held_vctx <= live.vctx;
        end else begin
          held_hi   <= '1;
          held_ctx  <= '1;
          held_vctx <= '1;
        end
      end
    end
  end

  AST_NOSMP_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && rd_lo && !live_ok) |=> (rsp_rdata == '1)); // R3
  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && sw_lock) |=> ($stable(held_hi) && $stable(held_ctx) && $stable(held_vctx))); // R4
  AST_NONLO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !rd_lo) |=> ($stable(held_hi) && $stable(held_ctx) && $stable(held_vctx))); // R7
  AST_RSP_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata))); // R9
  AST_LO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && rd_lo && live_ok) |=> (rsp_rdata == $past(live.addr[PCS_WORD_W-1:0]))); // R2
endmodule

// File: rtl/pcs_profiler.sv
module pcs_profiler
  import pcs_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  smp_valid,
  input  logic [PCS_PC_W-1:0]   smp_addr,
  input  logic                  smp_hv,
  input  logic                  smp_ns,
  input  logic [1:0]            smp_el,
  input  logic [PCS_WORD_W-1:0] smp_ctx,
  input  logic [PCS_WORD_W-1:0] smp_vctx,
  input  logic                  branch_retired,
  input  logic                  alt_fmt,
  input  logic                  sw_lock,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [PCS_ADDR_W-1:0] req_addr,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [PCS_WORD_W-1:0] rsp_rdata
);
  pcs_sample_t           smp_in, live;
  logic                  live_ok;
  logic [PCS_WORD_W-1:0] hi_fmt;

  always_comb begin
    smp_in.addr = smp_addr;
    smp_in.hv   = smp_hv;
    smp_in.ns   = smp_ns;
    smp_in.el   = smp_el;
    smp_in.ctx  = smp_ctx;
    smp_in.vctx = smp_vctx;
  end

  pcs_live u_live (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_in(smp_in),
    .branch_retired(branch_retired), .live(live), .live_ok(live_ok)
  );

  pcs_fmt u_fmt (.smp(live), .alt_fmt(alt_fmt), .hi_word(hi_fmt));

  pcs_regif u_regif (
    .clk(clk), .rst_n(rst_n), .live(live), .live_ok(live_ok), .hi_fmt(hi_fmt),
    .sw_lock(sw_lock), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata)
  );
endmodule

// File: tb/pcs_profiler_tb.sv
module pcs_profiler_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic [63:0] smp_addr = '0;
  logic        smp_hv = 1'b0, smp_ns = 1'b0;
  logic [1:0]  smp_el = '0;
  logic [31:0] smp_ctx = '0, smp_vctx = '0;
  logic        branch_retired = 1'b0, alt_fmt = 1'b0, sw_lock = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [11:0] req_addr = '0;
  logic        req_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  pcs_profiler dut_i (.*);

  localparam logic [11:0] A_LO = 12'h0A0, A_CTX = 12'h0A4, A_VC = 12'h0A8, A_HI = 12'h0AC;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; sw_lock = 1'b0; alt_fmt = 1'b0; rsp_ready = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic bus(input logic wr, input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    d = rsp_rdata;
    chk("R9 rsp_valid", {31'b0, rsp_valid}, 32'h1);
  endtask

  task automatic sample(input logic [63:0] a, input logic hv, input logic ns,
                        input logic [1:0] el, input logic [31:0] c, input logic [31:0] v);
    @(negedge clk);
    smp_valid = 1'b1; smp_addr = a; smp_hv = hv; smp_ns = ns; smp_el = el;
    smp_ctx = c; smp_vctx = v; branch_retired = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0; branch_retired = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    chk("R1 rsp_valid", {31'b0, rsp_valid}, 32'h0);
    bus(1'b0, A_HI, d);  chk("R1 hi", d, 32'h0);
    bus(1'b0, A_CTX, d); chk("R1 ctx", d, 32'h0);
    bus(1'b0, A_VC, d);  chk("R1 vctx", d, 32'h0);
  endtask

  task automatic t_presample();
    logic [31:0] d;
    do_reset();
    sw_lock = 1'b1;
    bus(1'b0, A_LO, d);  chk("R3 lo ones", d, 32'hFFFF_FFFF);
    bus(1'b0, A_HI, d);  chk("R4 locked hi kept", d, 32'h0);
    sw_lock = 1'b0;
    bus(1'b0, A_LO, d);  chk("R3 lo ones", d, 32'hFFFF_FFFF);
    bus(1'b0, A_HI, d);  chk("R3 hi ones", d, 32'hFFFF_FFFF);
    bus(1'b0, A_VC, d);  chk("R3 vctx ones", d, 32'hFFFF_FFFF);
  endtask

  task automatic t_nobranch();
    logic [31:0] d;
    do_reset();
    @(negedge clk);
    smp_valid = 1'b1; smp_addr = 64'h1111_2222_3333_4444; smp_hv = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
    bus(1'b0, A_LO, d);  chk("R3 no branch lo", d, 32'hFFFF_FFFF);
    bus(1'b0, A_CTX, d); chk("R3 no branch ctx", d, 32'hFFFF_FFFF);
  endtask

  task automatic t_default();
    logic [31:0] d;
    do_reset();
    sample(64'hDEAD_BEEF_0123_4567, 1'b1, 1'b0, 2'd1, 32'hC0C0_0001, 32'h5A5A_0001);
    bus(1'b0, A_LO, d);  chk("R2 lo", d, 32'h0123_4567);
    sample(64'h0BAD_F00D_89AB_CDEF, 1'b0, 1'b1, 2'd2, 32'hC0C0_0002, 32'h5A5A_0002);
    bus(1'b0, A_HI, d);  chk("R5 hi hv1 / R2 snapshot", d, 32'hDEAD_BEEF);
    bus(1'b0, A_CTX, d); chk("R2 ctx snapshot", d, 32'hC0C0_0001);
    bus(1'b0, A_VC, d);  chk("R7 vctx", d, 32'h5A5A_0001);
    bus(1'b0, A_HI, d);  chk("R7 hi reread", d, 32'hDEAD_BEEF);
    bus(1'b0, A_LO, d);  chk("R2 lo second", d, 32'h89AB_CDEF);
    bus(1'b0, A_HI, d);  chk("R5 hi hv0", d, 32'h0);
    bus(1'b0, A_CTX, d); chk("R2 ctx second", d, 32'hC0C0_0002);
  endtask

  task automatic t_alt();
    logic [31:0] d;
    do_reset();
    alt_fmt = 1'b1;
    sample(64'hFF12_3456_0000_0010, 1'b0, 1'b1, 2'd3, 32'h1, 32'h2);
    bus(1'b0, A_LO, d);  chk("R6 lo", d, 32'h0000_0010);
    bus(1'b0, A_HI, d);  chk("R6 hi ns el3", d, 32'hE012_3456);
    sample(64'h00AB_CDEF_0000_0020, 1'b1, 1'b0, 2'd1, 32'h3, 32'h4);
    bus(1'b0, A_LO, d);
    bus(1'b0, A_HI, d);  chk("R6 hi s el1", d, 32'h20AB_CDEF);
    alt_fmt = 1'b0;
  endtask

  task automatic t_lock();
    logic [31:0] d;
    do_reset();
    sample(64'hAAAA_0001_BBBB_0001, 1'b1, 1'b0, 2'd0, 32'h0000_00A1, 32'h0000_00B1);
    bus(1'b0, A_LO, d);
    sample(64'hCCCC_0002_DDDD_0002, 1'b1, 1'b0, 2'd0, 32'h0000_00A2, 32'h0000_00B2);
    sw_lock = 1'b1;
    bus(1'b0, A_LO, d);  chk("R4 lo data", d, 32'hDDDD_0002);
    bus(1'b0, A_HI, d);  chk("R4 hi kept", d, 32'hAAAA_0001);
    bus(1'b0, A_CTX, d); chk("R4 ctx kept", d, 32'h0000_00A1);
    sw_lock = 1'b0;
  endtask

  task automatic t_write();
    logic [31:0] d;
    do_reset();
    sample(64'h1234_5678_9ABC_DEF0, 1'b1, 1'b0, 2'd0, 32'h7, 32'h8);
    bus(1'b1, A_LO, d);  chk("R8 write data", d, 32'h0);
    bus(1'b0, A_HI, d);  chk("R8 write no snapshot", d, 32'h0);
    bus(1'b0, 12'h0B0, d); chk("R8 unmapped", d, 32'h0);
    bus(1'b0, A_LO, d);  chk("R8 lo after write", d, 32'h9ABC_DEF0);
  endtask

  task automatic t_stall();
    logic [31:0] d;
    do_reset();
    sample(64'h5555_6666_7777_8888, 1'b1, 1'b0, 2'd0, 32'h9, 32'hA);
    rsp_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = A_LO;
    @(negedge clk);
    req_addr = A_CTX;
    chk("R9 first rsp", rsp_rdata, 32'h7777_8888);
    chk("R9 ready low", {31'b0, req_ready}, 32'h0);
    @(negedge clk);
    chk("R9 held valid", {31'b0, rsp_valid}, 32'h1);
    chk("R9 held data", rsp_rdata, 32'h7777_8888);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 next rsp", rsp_rdata, 32'h0000_0009);
    @(negedge clk);
    chk("R9 drained", {31'b0, rsp_valid}, 32'h0);
  endtask

  initial begin
    fork
      begin
        t_reset(); t_presample(); t_nobranch(); t_default();
        t_alt(); t_lock(); t_write(); t_stall();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule